// File: doc/BRIEF.md
# Double-Buffered Real-Time Clock Register Front End

This block is the byte-wide register front end of a real-time clock. It covers the eight highest addresses of a small byte-addressed store. Everything below that window goes to a plain internal byte array. Inside the window, software sees a user copy of the calendar and time registers. This copy is kept apart from the running counters, which live in a separate counter block. That block is joined to this one by a snapshot input (`cntTime`), a load output (`loadStrobe` with `loadTime`), a one-second tick and a 512 Hz tick.

Two control bits in the century byte govern the user copy. The freeze bit (bit 6) captures the counters at the moment it is set, and the counters keep running. The hold bit (bit 7) stops refreshes so software can enter a new time. Clearing the hold bit transfers that time into the counters. When neither bit is set, the copy follows the counters on every one-second tick. The seconds byte carries an oscillator stop bit and the day byte carries a frequency test bit; both are also driven out to the counter block. The day byte also shows a read-only battery status bit. Every bit that is not a time field or a control bit behaves as plain storage.

Top module: `rtc_shadow_regs`

## Requirements
- R1: With the default 6-bit address, addresses 56..63 select the registers. The register index is the address minus 56: 0 century, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. Addresses 0..55 are a byte array that returns the last byte written.
- R2: A read is requested when ceN=0, oeN=0 and weN=1 at a rising edge. rdValid is 1 and rdData carries the byte after that edge. Otherwise rdValid=0 and rdData=0. A write happens when ceN=0 and weN=0, whatever oeN is, and it produces no read.
- R3: When century bits 6 and 7 are both 0, each secTick loads the time fields from cntTime, where byte i is cntTime[8i+7:8i]. The time field masks by index are 3F, 7F, 7F, 3F, 07, 3F, 1F, FF.
- R4: Writing the century byte with bit 6 = 1 while bit 6 was 0 loads all time fields from cntTime at that edge. While bit 6 stays 1, secTick changes nothing.
- R5: A write that clears century bit 6 does not refresh the time fields by itself. The next secTick refreshes all of them together.
- R6: While century bit 7 is 1, secTick changes nothing, and bus writes to time fields are kept.
- R7: A century write with bit 7 = 0 while bit 7 was 1 raises loadStrobe for exactly the one cycle after the write. In that cycle loadTime byte i equals user byte i ANDed with its time mask, and the century byte includes the value just written.
- R8: oscStop equals seconds bit 7 and freqTest equals day bit 6.
- R9: While day bit 6 = 1 and seconds bit 7 = 0, each hzTick inverts the value read back for seconds bit 0. With seconds bit 7 = 1, hzTick has no effect. Clearing day bit 6 returns the readback to the stored bit.
- R10: Day bit 7 reads as the battOk input. Writes to that bit are ignored, while the other bits of the day byte are stored.
- R11: Bits outside the time fields and control bits (minutes bit 7, hours bits 7:6, day bits 5:3, date bits 7:6, month bits 7:5) keep written values across secTick refreshes.
- R12: When a bus write and a refresh hit the same register in one cycle, the written byte wins for that register, and the other registers are still refreshed.
- R13: Reset clears the user copy, rdValid, rdData, loadStrobe, oscStop and freqTest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, zero when rdValid is low |
| rdValid | output | 1 | Read data valid, one cycle after a read request |
| secTick | input | 1 | One-second tick from the counter block |
| hzTick | input | 1 | 512 Hz tick from the counter block |
| battOk | input | 1 | Battery status shown in day bit 7 |
| cntTime | input | 64 | Running counter values, byte i per register index |
| loadStrobe | output | 1 | One-cycle request to load counters |
| loadTime | output | 64 | Masked user copy to be loaded |
| oscStop | output | 1 | Oscillator stop setting |
| freqTest | output | 1 | Frequency test setting |

## Verification
The embedded assertions watch three things on every cycle. The first is the read timing, with zero data when idle. The second is that the user copy stays frozen while either century control bit is set and no bus write occurs. The third is that the load pulse is a single cycle and follows a falling hold bit. What only the bench scenarios can show is the data itself. That covers the snapshot against refresh timing around the freeze bit, the masked merge of time fields with spare bits, the load contents, the 512 Hz readback inversion and the battery bit substitution. It also covers the priority of a write over a tick in the same cycle, and the byte array below the window.

// File: rtl/rtcfe_pkg.sv
package rtcfe_pkg;
  localparam int REG_CNT = 8;
  localparam int IDX_W = $clog2(REG_CNT);
  localparam int IDX_CENT = 0;
  localparam int IDX_SEC = 1;
  localparam int IDX_DAY = 4;
  localparam int BIT_HOLD = 7;
  localparam int BIT_FREEZE = 6;
  localparam int BIT_OSC = 7;
  localparam int BIT_FT = 6;
  localparam int BIT_BATT = 7;
  // time-field mask per register index, index 0 in the low byte
  localparam logic [8*REG_CNT-1:0] TIME_MASKS = 64'hFF1F_3F07_3F7F_7F3F;

  typedef struct packed {
    logic inWin;
    logic winWr;
    logic ramWr;
    logic rdReq;
    logic snap;
    logic refresh;
    logic [IDX_W-1:0] idx;
  } rtcStrobe_t;
endpackage

// File: rtl/rtcfe_ram.sv
module rtcfe_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdByte
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[addr] <= wrData;
  end

  assign rdByte = mem[addr];
endmodule

// File: rtl/rtcfe_ctrl.sv
module rtcfe_ctrl
  import rtcfe_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        ctlData,   // wrData[7:6]
  input  logic              secTick,
  input  logic              flagFreeze,
  input  logic              flagHold,
  output rtcStrobe_t        stb,
  output logic              loadStrobe
);
  logic wrAct, rdAct, inWin, centWr;

  always_comb begin
    wrAct = !ceN && !weN;
    rdAct = !ceN && !oeN && weN;
    inWin = &addr[ADDR_W-1:IDX_W];
    centWr = wrAct && inWin && (addr[IDX_W-1:0] == IDX_W'(IDX_CENT));

    stb.inWin   = inWin;
    stb.winWr   = wrAct && inWin;
    stb.ramWr   = wrAct && !inWin;
    stb.rdReq   = rdAct;
    stb.idx     = addr[IDX_W-1:0];
    stb.snap    = centWr && ctlData[BIT_FREEZE-6] && !flagFreeze;
    stb.refresh = secTick && !flagFreeze && !flagHold;
  end

  always_ff @(posedge clk) begin
    if (!rstN) loadStrobe <= 1'b0;
    else       loadStrobe <= centWr && flagHold && !ctlData[BIT_HOLD-6];
  end

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> !loadStrobe); // R7
  AST_LOAD_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> ($past(flagHold) && !flagHold)); // R7
endmodule

// File: rtl/rtcfe_dp.sv
module rtcfe_dp
  import rtcfe_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  rtcStrobe_t             stb,
  input  logic [7:0]             wrData,
  input  logic [7:0]             ramByte,
  input  logic [8*REG_CNT-1:0]   cntTime,
  input  logic                   hzTick,
  input  logic                   battOk,
  output logic [7:0]             rdData,
  output logic                   rdValid,
  output logic                   flagFreeze,
  output logic                   flagHold,
  output logic [8*REG_CNT-1:0]   loadTime,
  output logic                   oscStop,
  output logic                   freqTest
);
  logic [7:0] userReg [REG_CNT];
  logic [8*REG_CNT-1:0] userFlat;
  logic [7:0] winByte;
  logic ftPhase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_CNT; i++) userReg[i] <= '0;
    end else begin
      for (int i = 0; i < REG_CNT; i++) begin
        if (stb.winWr && stb.idx == IDX_W'(i)) begin
          userReg[i] <= wrData;
          if (i == IDX_DAY) userReg[i][BIT_BATT] <= 1'b0;
        end else if (stb.snap || stb.refresh) begin
          userReg[i] <= (userReg[i] & ~TIME_MASKS[8*i +: 8])
                      | (cntTime[8*i +: 8] & TIME_MASKS[8*i +: 8]);
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < REG_CNT; i++) begin
      userFlat[8*i +: 8] = userReg[i];
      loadTime[8*i +: 8] = userReg[i] & TIME_MASKS[8*i +: 8];
    end
  end

  assign flagFreeze = userReg[IDX_CENT][BIT_FREEZE];
  assign flagHold   = userReg[IDX_CENT][BIT_HOLD];
  assign oscStop    = userReg[IDX_SEC][BIT_OSC];
  assign freqTest   = userReg[IDX_DAY][BIT_FT];

  always_ff @(posedge clk) begin
    if (!rstN || !freqTest) ftPhase <= 1'b0;
    else if (hzTick && !oscStop) ftPhase <= ~ftPhase;
  end

  always_comb begin
    winByte = userReg[stb.idx];
    if (stb.idx == IDX_W'(IDX_DAY)) winByte[BIT_BATT] = battOk;
    if (stb.idx == IDX_W'(IDX_SEC)) winByte[0] = winByte[0] ^ ftPhase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.rdReq;
      rdData  <= stb.rdReq ? (stb.inWin ? winByte : ramByte) : 8'h00;
    end
  end

  AST_COPY_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    ((flagFreeze || flagHold) && !stb.winWr) |=> $stable(userFlat)); // R4 R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == 8'h00)); // R2
endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
  import rtcfe_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ceN,
  input  logic                 oeN,
  input  logic                 weN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           wrData,
  output logic [7:0]           rdData,
  output logic                 rdValid,
  input  logic                 secTick,
  input  logic                 hzTick,
  input  logic                 battOk,
  input  logic [8*REG_CNT-1:0] cntTime,
  output logic                 loadStrobe,
  output logic [8*REG_CNT-1:0] loadTime,
  output logic                 oscStop,
  output logic                 freqTest
);
  rtcStrobe_t stb;
  logic flagFreeze, flagHold;
  logic [7:0] ramByte;

  rtcfe_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .addr(addr),
    .ctlData(wrData[7:6]), .secTick(secTick), .flagFreeze(flagFreeze),
    .flagHold(flagHold), .stb(stb), .loadStrobe(loadStrobe)
  );

  rtcfe_ram #(.ADDR_W(ADDR_W), .DATA_W(8)) uRam (
    .clk(clk), .wrEn(stb.ramWr), .addr(addr), .wrData(wrData), .rdByte(ramByte)
  );

  rtcfe_dp uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .ramByte(ramByte),
    .cntTime(cntTime), .hzTick(hzTick), .battOk(battOk), .rdData(rdData),
    .rdValid(rdValid), .flagFreeze(flagFreeze), .flagHold(flagHold),
    .loadTime(loadTime), .oscStop(oscStop), .freqTest(freqTest)
  );

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(!ceN && !oeN && weN)); // R2
endmodule

// File: tb/rtc_shadow_regs_test.sv
`timescale 1ns/1ps
module rtc_shadow_regs_test;
  localparam int AW = 6;
  localparam int WBASE = 56;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic rdValid;
  logic secTick = 1'b0, hzTick = 1'b0, battOk = 1'b1;
  logic [63:0] cntTime;
  logic loadStrobe, oscStop, freqTest;
  logic [63:0] loadTime;

  logic [7:0] cntB [8];
  logic [7:0] mdl [8];
  logic ftPh = 1'b0;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] expQ [$];
  string tagQ [$];

  always #2.5 clk = ~clk;

  always_comb for (int i = 0; i < 8; i++) cntTime[8*i +: 8] = cntB[i];

  rtc_shadow_regs #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .secTick(secTick),
    .hzTick(hzTick), .battOk(battOk), .cntTime(cntTime), .loadStrobe(loadStrobe),
    .loadTime(loadTime), .oscStop(oscStop), .freqTest(freqTest)
  );

  function automatic logic [7:0] fmask(int i);
    case (i)
      0: return 8'h3F;
      1: return 8'h7F;
      2: return 8'h7F;
      3: return 8'h3F;
      4: return 8'h07;
      5: return 8'h3F;
      6: return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] expRead(int i);
    logic [7:0] v;
    v = mdl[i];
    if (i == 4) v[7] = battOk;
    if (i == 1) v[0] = v[0] ^ ftPh;
    return v;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mdlRefresh();
    for (int i = 0; i < 8; i++) mdl[i] = (mdl[i] & ~fmask(i)) | (cntB[i] & fmask(i));
  endtask

  task automatic mdlWrite(int i, logic [7:0] d);
    if (i == 0 && d[6] && !mdl[0][6]) mdlRefresh();
    if (i == 4 && !d[6]) ftPh = 1'b0;
    mdl[i] = (i == 4) ? (d & 8'h7F) : d;
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rdValid && !done) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected read actual=%h expected=none", rdData);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (rdData !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", t, rdData, e);
        end
      end
    end
  end

  task automatic busIdle();
    ceN = 1'b1; oeN = 1'b1; weN = 1'b1; secTick = 1'b0; hzTick = 1'b0;
  endtask

  task automatic busWrite(int a, logic [7:0] d, bit oeLow = 0);
    @(negedge clk);
    ceN = 1'b0; weN = 1'b0; oeN = oeLow ? 1'b0 : 1'b1; addr = AW'(a); wrData = d;
    if (a >= WBASE) mdlWrite(a - WBASE, d);
    @(negedge clk);
    busIdle();
    check("R2 no read on write", {63'd0, rdValid}, 64'd0);
  endtask

  task automatic busRead(int a, logic [7:0] exp, string tag);
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b0; weN = 1'b1; addr = AW'(a);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    busIdle();
  endtask

  task automatic readAll(string tag);
    for (int i = 0; i < 8; i++) busRead(WBASE + i, expRead(i), tag);
  endtask

  task automatic tick();
    @(negedge clk);
    secTick = 1'b1;
    if (!mdl[0][6] && !mdl[0][7]) mdlRefresh();
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic hzPulse();
    @(negedge clk);
    hzTick = 1'b1;
    if (mdl[4][6] && !mdl[1][7]) ftPh = ~ftPh;
    @(negedge clk);
    hzTick = 1'b0;
  endtask

  task automatic setCnt(logic [7:0] c, logic [7:0] s, logic [7:0] mi, logic [7:0] h,
                        logic [7:0] dy, logic [7:0] dt, logic [7:0] mo, logic [7:0] y);
    cntB[0] = c; cntB[1] = s; cntB[2] = mi; cntB[3] = h;
    cntB[4] = dy; cntB[5] = dt; cntB[6] = mo; cntB[7] = y;
  endtask

  task automatic writeCentLoad(logic [7:0] d);
    logic [63:0] e;
    @(negedge clk);
    ceN = 1'b0; weN = 1'b0; oeN = 1'b1; addr = AW'(WBASE); wrData = d;
    mdlWrite(0, d);
    for (int i = 0; i < 8; i++) e[8*i +: 8] = mdl[i] & fmask(i);
    @(negedge clk);
    busIdle();
    check("R7 load pulse high", {63'd0, loadStrobe}, 64'd1);
    check("R7 load contents", loadTime, e);
    @(negedge clk);
    check("R7 load pulse single", {63'd0, loadStrobe}, 64'd0);
  endtask

  task automatic writeWithTick(int i, logic [7:0] d);
    @(negedge clk);
    ceN = 1'b0; weN = 1'b0; oeN = 1'b1; addr = AW'(WBASE + i); wrData = d;
    secTick = 1'b1;
    if (!mdl[0][6] && !mdl[0][7]) mdlRefresh();
    mdlWrite(i, d);
    @(negedge clk);
    busIdle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    setCnt(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    busIdle();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13 reset state
    check("R13 rdValid", {63'd0, rdValid}, 64'd0);
    check("R13 rdData", {56'd0, rdData}, 64'd0);
    check("R13 loadStrobe", {63'd0, loadStrobe}, 64'd0);
    check("R13 osc/ft", {62'd0, oscStop, freqTest}, 64'd0);
    readAll("R13 user copy after reset");

    // R1 byte array below the window, R2 write with oeN low
    busWrite(0, 8'hA5);
    busWrite(5, 8'h3C, 1);
    busWrite(55, 8'h81);
    busRead(0, 8'hA5, "R1 ram 0");
    busRead(5, 8'h3C, "R2 ram 5 written with oeN low");
    busRead(55, 8'h81, "R1 ram 55");

    // R3 refresh on tick
    setCnt(8'h20, 8'h45, 8'h30, 8'h12, 8'h03, 8'h15, 8'h06, 8'h24);
    tick();
    readAll("R3 refresh");

    // R11 spare bits survive refresh
    busWrite(WBASE + 2, 8'h91);
    busWrite(WBASE + 3, 8'hC2);
    busWrite(WBASE + 4, 8'h2B);
    busWrite(WBASE + 5, 8'h41);
    busWrite(WBASE + 6, 8'hA2);
    setCnt(8'h20, 8'h46, 8'h31, 8'h13, 8'h04, 8'h16, 8'h07, 8'h25);
    tick();
    readAll("R11 spare bits kept R3");

    // R4 freeze snapshot
    setCnt(8'h20, 8'h47, 8'h31, 8'h13, 8'h04, 8'h16, 8'h07, 8'h25);
    busWrite(WBASE, 8'h60);
    readAll("R4 snapshot at freeze");
    setCnt(8'h20, 8'h48, 8'h32, 8'h14, 8'h05, 8'h17, 8'h08, 8'h26);
    tick();
    readAll("R4 frozen across tick");
    // R5 clearing freeze waits for next tick
    busWrite(WBASE, 8'h20);
    readAll("R5 no refresh on clear");
    tick();
    readAll("R5 refresh on next tick");

    // R6 hold bit
    busWrite(WBASE, 8'hA0);
    setCnt(8'h20, 8'h55, 8'h40, 8'h20, 8'h06, 8'h18, 8'h09, 8'h27);
    tick();
    readAll("R6 hold blocks tick");
    busWrite(WBASE + 1, 8'h10);
    busWrite(WBASE + 2, 8'h05);
    busWrite(WBASE + 7, 8'h99);
    tick();
    readAll("R6 loaded values kept");
    // R7 transfer on hold clear
    writeCentLoad(8'h19);
    readAll("R7 copy after load");

    // R10 battery bit
    busWrite(WBASE + 4, 8'h85);
    busRead(WBASE + 4, expRead(4), "R10 batt ok");
    battOk = 1'b0;
    busRead(WBASE + 4, expRead(4), "R10 batt low");
    battOk = 1'b1;

    // R8 / R9 frequency test and oscillator stop
    busWrite(WBASE + 4, 8'h45);
    check("R8 freqTest", {63'd0, freqTest}, 64'd1);
    busRead(WBASE + 1, expRead(1), "R9 seconds before toggle");
    hzPulse();
    busRead(WBASE + 1, expRead(1), "R9 seconds toggled once");
    hzPulse();
    busRead(WBASE + 1, expRead(1), "R9 seconds toggled twice");
    hzPulse();
    busWrite(WBASE + 1, 8'h90);
    check("R8 oscStop", {63'd0, oscStop}, 64'd1);
    hzPulse();
    busRead(WBASE + 1, expRead(1), "R9 no toggle with osc stopped");
    busWrite(WBASE + 4, 8'h05);
    check("R8 freqTest cleared", {63'd0, freqTest}, 64'd0);
    busRead(WBASE + 1, expRead(1), "R9 stored bit after ft clear");
    busWrite(WBASE + 1, 8'h10);
    check("R8 oscStop cleared", {63'd0, oscStop}, 64'd0);

    // R12 write beats refresh in the same cycle
    setCnt(8'h21, 8'h01, 8'h02, 8'h03, 8'h02, 8'h04, 8'h05, 8'h06);
    writeWithTick(2, 8'h2A);
    readAll("R12 write wins, others refreshed");

    repeat (4) @(negedge clk);
    check("R2 all reads returned", 64'(expQ.size()), 64'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule